// File: doc/BRIEF.md
# Polynomial Sequence Self-Test Checker

This block judges whether a captured buffer of W-bit words matches the output of a known polynomial sequence. A start strobe loads a seed word. The seed is one of two built-in constants, and an input chooses which. The polynomial comes from an input port. The block then works through expected values in steps. In each step it reads every buffer word except slot 0 through a synchronous read port and counts the words equal to the current expected value. It then advances the expected value by one polynomial shift.

Match counts add up across steps. The check passes as soon as the running total reaches a goal at the end of a step. It fails if the goal is still unmet after a set maximum number of steps. Completion is signalled by a one-cycle `done` pulse. The `pass` verdict stays valid until the next run starts. Buffer depth, step limit and match goal are parameters. Filling the buffer is the job of other logic.

Top module: `polyseq_selftest`

## Requirements
- R1: A start pulse accepted while idle loads the expected value from SEED0 when `seed_sel` is 0, or from SEED1 when it is 1. It clears `pass` on the following cycle and begins step 1.
- R2: Each step issues exactly one read per cycle at addresses 1, 2, …, DEPTH-1, in ascending order. Address 0 is never read, so a word in slot 0 never counts as a match. `rd_en` is low while idle.
- R3: Between steps the expected value becomes (value << 1), XORed with `poly` only when bit W-1 of the old value was 1.
- R4: Matches found in different steps add into one running total, which is not reset between steps.
- R5: If the total is at least MATCH_GOAL after step k, the run ends with `pass`=1. No further step is made, and `done` is high k*(DEPTH+1) cycles after the edge that accepted start.
- R6: If the goal is not met after step MAX_STEPS, the run ends with `pass`=0, and `done` is high MAX_STEPS*(DEPTH+1) cycles after the accepting edge.
- R7: `done` is high for exactly one cycle per run. `pass` keeps its value from that pulse until the next accepted start.
- R8: A start pulse while a run is in progress has no effect on that run's verdict or timing.
- R9: During and directly after reset, `done`, `pass` and `rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check (honoured only when idle) |
| seed_sel | input | 1 | Seed choice: 0 selects SEED0, 1 selects SEED1 |
| poly | input | W | Feedback polynomial for the step advance |
| rd_en | output | 1 | Buffer read request |
| rd_addr | output | $clog2(DEPTH) | Buffer read address |
| rd_data | input | W | Buffer word, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Verdict, held until the next accepted start |

## Verification
The verdict is due exactly steps*(DEPTH+1) cycles after the edge that accepts start. Each step takes DEPTH-1 read cycles, one cycle for the last buffer word to return, and one evaluation cycle. `pass` must read 0 one cycle after that accepting edge.

The scoreboard entry pushed by the driver records the cycle of the accepting edge, the expected verdict and the expected latency. The expected verdict and latency come from a bench model of the step rule. The monitor samples on the falling edge and subtracts the recorded cycle from a free-running cycle count. It also checks that the `done` pulse ends one cycle later.

// File: rtl/polyseq_pkg.sv
package polyseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DRAIN,
    ST_EVAL
  } seq_state_t;
endpackage

// File: rtl/polyseq_advance.sv
// One step of the expected-value sequence: shift left, fold in poly on carry-out.
module polyseq_advance #(
  parameter int W = 64
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] poly,
  output logic [W-1:0] nxt
);
  always_comb begin
    nxt = {cur[W-2:0], 1'b0};
    if (cur[W-1]) nxt = nxt ^ poly;
  end
endmodule

// File: rtl/polyseq_match_accum.sv
// Compares returning buffer words with the expected value and keeps a running total.
module polyseq_match_accum #(
  parameter int W          = 64,
  parameter int GOAL       = 4,
  parameter int TOTAL_MAX  = 120
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         rd_en,
  input  logic [W-1:0] rd_data,
  input  logic [W-1:0] expected,
  output logic         goal_met
);
  localparam int CW = $clog2(TOTAL_MAX + 1) + 1;

  logic          vld_q;
  logic [CW-1:0] total_q;

  always_ff @(posedge clk) begin
    if (rst || clr) vld_q <= 1'b0;
    else            vld_q <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      total_q <= '0;
    else if (vld_q && (rd_data == expected))
      total_q <= total_q + CW'(1);
  end

  assign goal_met = (total_q >= CW'(GOAL));
endmodule

// File: rtl/polyseq_selftest.sv
module polyseq_selftest
  import polyseq_pkg::*;
#(
  parameter int          W          = 64,
  parameter int          DEPTH      = 16,
  parameter int          MAX_STEPS  = 8,
  parameter int          MATCH_GOAL = 4,
  parameter logic [W-1:0] SEED0     = 64'h0123_4567_89AB_CDEF,
  parameter logic [W-1:0] SEED1     = 64'h8000_0000_0000_0001,
  localparam int         AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          seed_sel,
  input  logic [W-1:0]  poly,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  rd_data,
  output logic          done,
  output logic          pass
);
  localparam int SW = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;

  seq_state_t    state_q;
  logic [W-1:0]  exp_q;
  logic [W-1:0]  exp_nxt;
  logic [SW-1:0] step_q;
  logic [AW-1:0] addr_q;
  logic          done_q;
  logic          pass_q;
  logic          accept;
  logic          goal_met;
  logic          busy;

  assign busy   = (state_q != ST_IDLE);
  assign accept = (state_q == ST_IDLE) && start;

  polyseq_advance #(.W(W)) u_adv (
    .cur  (exp_q),
    .poly (poly),
    .nxt  (exp_nxt)
  );

  polyseq_match_accum #(
    .W         (W),
    .GOAL      (MATCH_GOAL),
    .TOTAL_MAX (MAX_STEPS * (DEPTH - 1))
  ) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .expected (exp_q),
    .goal_met (goal_met)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      exp_q   <= '0;
      step_q  <= '0;
      addr_q  <= AW'(1);
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            exp_q   <= seed_sel ? SEED1 : SEED0;
            step_q  <= '0;
            addr_q  <= AW'(1);
            pass_q  <= 1'b0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          addr_q <= addr_q + AW'(1);
          if (addr_q == AW'(DEPTH - 1)) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_EVAL;
        ST_EVAL: begin
          if (goal_met) begin
            done_q  <= 1'b1;
            pass_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (step_q == SW'(MAX_STEPS - 1)) begin
            done_q  <= 1'b1;
            pass_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            exp_q   <= exp_nxt;
            step_q  <= step_q + SW'(1);
            addr_q  <= AW'(1);
            state_q <= ST_SCAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en   = (state_q == ST_SCAN);
  assign rd_addr = addr_q;
  assign done    = done_q;
  assign pass    = pass_q;
endmodule

// File: rtl/polyseq_selftest_chk.sv
module polyseq_selftest_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          done,
  input logic          pass
);
  assert_no_slot0_read_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr != '0));

  assert_ascending_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + AW'(1)));

  assert_idle_no_read_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_en);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_pass_rise_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pass) |-> done);

  assert_pass_fall_on_start_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pass) |-> $past(start && !busy));

  assert_start_clears_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (!pass && busy));
endmodule

bind polyseq_selftest polyseq_selftest_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .done    (done),
  .pass    (pass)
);

// File: tb/sim_polyseq_selftest.sv
module sim_polyseq_selftest;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 64;
  localparam int DEPTH      = 8;
  localparam int MAX_STEPS  = 4;
  localparam int GOAL       = 3;
  localparam int AW         = $clog2(DEPTH);
  localparam logic [63:0] SEED_A = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] SEED_B = 64'h8000_0000_0000_0001;
  localparam logic [63:0] POLY   = 64'h2400_0000_0000_0087;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          seed_sel = 1'b0;
  logic [W-1:0]  poly = POLY;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [W-1:0]  rd_data;
  logic          done;
  logic          pass;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit prev_done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  polyseq_selftest #(
    .W(W), .DEPTH(DEPTH), .MAX_STEPS(MAX_STEPS), .MATCH_GOAL(GOAL),
    .SEED0(SEED_A), .SEED1(SEED_B)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .seed_sel(seed_sel), .poly(poly),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .pass(pass)
  );

  // Word buffer with a synchronous read port
  logic [W-1:0] mem [DEPTH];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit    exp_pass;
    int    exp_lat;
    int    t0;
    string tag;
  } item_t;
  item_t sb[$];

  function automatic logic [63:0] adv(input logic [63:0] x);
    return {x[62:0], 1'b0} ^ (x[63] ? POLY : 64'h0);
  endfunction

  // Reference: steps taken and verdict, straight from the requirement text
  task automatic model(input bit sel, output bit ok, output int steps);
    logic [63:0] e;
    int total;
    e = sel ? SEED_B : SEED_A;
    total = 0;
    ok = 1'b0;
    steps = MAX_STEPS;
    for (int st = 0; st < MAX_STEPS; st++) begin
      for (int i = 1; i < DEPTH; i++) if (mem[i] == e) total++;
      if (total >= GOAL) begin
        ok = 1'b1;
        steps = st + 1;
        break;
      end
      e = adv(e);
    end
  endtask

  task automatic fill_bg();
    for (int i = 0; i < DEPTH; i++) mem[i] = 64'hC0DE_5A5A_0000_0000 + 64'(i) * 64'h1_0001_0003;
  endtask

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: predict, pulse start, push scoreboard item, wait for the monitor
  task automatic run(input bit sel, input string tag, input bit poke_busy, input int want_steps);
    bit ok;
    int steps;
    item_t it;
    model(sel, ok, steps);
    chk(steps == want_steps, tag, "stimulus step count", 64'(steps), 64'(want_steps));
    @(negedge clk);
    seed_sel = sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    it.exp_pass = ok;
    it.exp_lat  = steps * (DEPTH + 1);
    it.t0       = cyc;
    it.tag      = tag;
    sb.push_back(it);
    chk(pass === 1'b0, "R1", "pass cleared after start", 64'(pass), 64'd0);
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      seed_sel = ~sel;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      seed_sel = sel;
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor: pop and compare when a result appears
  always @(negedge clk) begin
    item_t it;
    if (!rst) begin
      if (prev_done) chk(done === 1'b0, "R7", "done longer than one cycle", 64'(done), 64'd0);
      if (done === 1'b1) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", 64'd1, 64'd0);
        end else begin
          it = sb.pop_front();
          chk(pass === it.exp_pass, it.tag, "verdict", 64'(pass), 64'(it.exp_pass));
          chk((cyc - it.t0) == it.exp_lat, it.tag, "latency", 64'(cyc - it.t0), 64'(it.exp_lat));
        end
      end
    end
    prev_done = (done === 1'b1);
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5/R6 completion: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    fill_bg();
    repeat (2) @(negedge clk);
    // R9: reset state
    chk(done === 1'b0, "R9", "done in reset", 64'(done), 64'd0);
    chk(pass === 1'b0, "R9", "pass in reset", 64'(pass), 64'd0);
    chk(rd_en === 1'b0, "R9", "rd_en in reset", 64'(rd_en), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(done === 1'b0 && pass === 1'b0 && rd_en === 1'b0, "R9", "outputs after reset",
        {61'd0, done, pass, rd_en}, 64'd0);

    // R5/R1: three seed words, pass on step 1
    fill_bg();
    for (int i = 1; i <= 3; i++) mem[i] = SEED_A;
    run(1'b0, "R5", 1'b0, 1);

    // R7: pass held, done stays low
    repeat (5) @(negedge clk);
    chk(pass === 1'b1, "R7", "pass held", 64'(pass), 64'd1);
    chk(done === 1'b0, "R7", "done idle", 64'(done), 64'd0);

    // R4: two matches in step 1, one more in step 2
    fill_bg();
    mem[1] = SEED_A; mem[2] = SEED_A; mem[5] = adv(SEED_A);
    run(1'b0, "R4", 1'b0, 2);

    // R2: slot 0 holds a match but must not count; run fails
    fill_bg();
    mem[0] = SEED_A; mem[1] = SEED_A; mem[2] = SEED_A;
    run(1'b0, "R2", 1'b0, MAX_STEPS);

    // R3: seed with top bit set, matches only on advanced value
    fill_bg();
    for (int i = 1; i <= 3; i++) mem[i] = adv(SEED_B);
    run(1'b1, "R3", 1'b0, 2);

    // R3: top bit clear, plain shift
    fill_bg();
    for (int i = 4; i <= 6; i++) mem[i] = adv(SEED_A);
    run(1'b0, "R3", 1'b0, 2);

    // R1: same buffer with the other seed choice fails
    fill_bg();
    for (int i = 1; i <= 3; i++) mem[i] = SEED_B;
    run(1'b1, "R1", 1'b0, 1);
    run(1'b0, "R1", 1'b0, MAX_STEPS);

    // R6: goal met on the final allowed step passes; otherwise fail
    fill_bg();
    for (int i = 5; i <= 7; i++) mem[i] = adv(adv(adv(SEED_A)));
    run(1'b0, "R6", 1'b0, MAX_STEPS);
    fill_bg();
    run(1'b0, "R6", 1'b0, MAX_STEPS);

    // R8: start during a run with the other seed choice is ignored
    fill_bg();
    mem[1] = SEED_A; mem[2] = SEED_A; mem[3] = adv(SEED_A);
    run(1'b0, "R8", 1'b1, 2);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule